// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port memory and decides which port keeps the word when both ports select the same address at the same time. The ports are called left and right. Each port presents an enable, an address and a write request. On every clock the arbiter compares the two ports. If both are enabled on one address, the port that got there first keeps access and the other port sees its busy flag raised. The busy decision is combinational from the current port inputs plus one cycle of registered history, so a losing write is blocked in the same cycle it collides.

A mode input sets the role of the busy lines. When it is high the block is a master: it computes the busy flags and drives them out. When it is low the block is a slave: its busy outputs stay low and it takes the busy flags from outside. This lets several devices form a wider word while sharing one arbitration result from the master. In both modes each port has a write-permit output. That output is the port's write request, masked by the busy flag that currently applies to that port.

Top module: `dp_contention_arbiter`

## Requirements
- R1: A busy output is raised only when both port enables are high and the two addresses are equal. An enabled port facing a disabled opponent on the same address gets no busy.
- R2: Suppose one port is enabled and its address is unchanged since the previous clock, and the other port's address moves onto it. The moving port gets busy and the stable port keeps access.
- R3: Suppose the addresses already match and one port is enabled. The port whose enable rises in that cycle gets busy.
- R4: In the same cycle that the addresses differ, or that the opposing enable goes low, the busy flag falls.
- R5: If both ports reach a match in the same cycle, the left port wins and only the right busy rises (left_busy_out=0, right_busy_out=1).
- R6: In master mode, at most one busy output is high in any cycle. During contention exactly one is high. The winner is held for as long as the contention lasts, even if both ports later move together to another shared address.
- R7: In slave mode (master_mode=0), both busy outputs stay low. A port whose busy input is high has its write permit held low.
- R8: A write permit equals the port's write request ANDed with the inverse of the busy flag that applies to it: the computed flag in master mode, the input flag in slave mode.
- R9: While rst_n is low, both busy outputs are low and the history is cleared. A contention present when reset is released is therefore treated as simultaneous, and the left port wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| master_mode | input | 1 | 1 selects master, 0 selects slave |
| left_en | input | 1 | Left port enable |
| left_addr | input | AW | Left port word address |
| left_wr | input | 1 | Left port write request |
| right_en | input | 1 | Right port enable |
| right_addr | input | AW | Right port word address |
| right_wr | input | 1 | Right port write request |
| left_busy_in | input | 1 | Imported busy for the left port (slave mode) |
| right_busy_in | input | 1 | Imported busy for the right port (slave mode) |
| left_busy_out | output | 1 | Left port lost contention (master mode) |
| right_busy_out | output | 1 | Right port lost contention (master mode) |
| left_wr_ok | output | 1 | Left write permitted |
| right_wr_ok | output | 1 | Right write permitted |

## Verification
The bench sweeps every ordered pair of port states on a 2-bit address space, in both modes, with the write requests and imported busy flags varied. This covers arrival by address move, arrival by enable and simultaneous arrival.

A design that read the tie-break the wrong way would raise the left busy on a simultaneous match. A design that re-arbitrated every cycle would hand the word to the loser once both ports had settled, or once they moved together to a new shared address. A design with a registered busy would leave a losing write permitted for one cycle. Other directed cases target specific faults. Release by opponent disable catches a design that releases only on an address mismatch. Reset release during contention catches a design that keeps stale history. Slave mode with imported busy catches a design that gates writes with the internally computed flag.

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          left_en,
  input  logic [AW-1:0] left_addr,
  input  logic          left_wr,
  input  logic          right_en,
  input  logic [AW-1:0] right_addr,
  input  logic          right_wr,
  input  logic          left_busy_in,
  input  logic          right_busy_in,
  output logic          left_busy_out,
  output logic          right_busy_out,
  output logic          left_wr_ok,
  output logic          right_wr_ok
);

  typedef enum logic [1:0] {OWN_NONE = 2'd0, OWN_LEFT = 2'd1, OWN_RIGHT = 2'd2} owner_t;

  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  owner_t        hold_q, owner;
  logic          clash, l_early, r_early, l_lose, r_lose, l_block, r_block;

  assign clash   = left_en & right_en & (left_addr == right_addr);
  assign l_early = l_en_q & (l_addr_q == left_addr);
  assign r_early = r_en_q & (r_addr_q == right_addr);

  always_comb begin
    owner = OWN_NONE;
    if (rst_n && clash) begin
      if (hold_q != OWN_NONE)       owner = hold_q;
      else if (r_early && !l_early) owner = OWN_RIGHT;
      else                          owner = OWN_LEFT;
    end
  end

  assign l_lose = (owner == OWN_RIGHT);
  assign r_lose = (owner == OWN_LEFT);

  assign left_busy_out  = master_mode & l_lose;
  assign right_busy_out = master_mode & r_lose;

  assign l_block = master_mode ? l_lose : left_busy_in;
  assign r_block = master_mode ? r_lose : right_busy_in;

  assign left_wr_ok  = left_wr  & ~l_block;
  assign right_wr_ok = right_wr & ~r_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      hold_q   <= OWN_NONE;
    end else begin
      l_en_q   <= left_en;
      r_en_q   <= right_en;
      l_addr_q <= left_addr;
      r_addr_q <= right_addr;
      hold_q   <= owner;
    end
  end

  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  // R1
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_busy_out || right_busy_out) |-> (left_en && right_en && left_addr == right_addr));

  // R6
  single_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({left_busy_out, right_busy_out}));

  // R6
  contention_has_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && left_en && right_en && left_addr == right_addr)
      |-> $countones({left_busy_out, right_busy_out}) == 1);

  // R6
  winner_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(right_busy_out) && master_mode && left_en && right_en
      && left_addr == right_addr) |-> right_busy_out);

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!left_busy_out && !right_busy_out));

  // R7
  slave_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (left_busy_in || right_busy_in))
      |-> !((left_busy_in && left_wr_ok) || (right_busy_in && right_wr_ok)));

  // R8
  master_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (left_busy_out || right_busy_out))
      |-> !((left_busy_out && left_wr_ok) || (right_busy_out && right_wr_ok)));

endmodule

// File: tb/test_dp_contention_arbiter.sv
module test_dp_contention_arbiter;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic left_en = 1'b0, right_en = 1'b0, left_wr = 1'b0, right_wr = 1'b0;
  logic left_busy_in = 1'b0, right_busy_in = 1'b0;
  logic [AW-1:0] left_addr = '0, right_addr = '0;
  logic left_busy_out, right_busy_out, left_wr_ok, right_wr_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference history
  bit m_le = 0, m_re = 0;
  int m_la = 0, m_ra = 0;
  int m_own = 0;

  always #2.5 clk = ~clk;

  dp_contention_arbiter #(.AW(AW)) i_dp_contention_arbiter (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .left_en(left_en), .left_addr(left_addr), .left_wr(left_wr),
    .right_en(right_en), .right_addr(right_addr), .right_wr(right_wr),
    .left_busy_in(left_busy_in), .right_busy_in(right_busy_in),
    .left_busy_out(left_busy_out), .right_busy_out(right_busy_out),
    .left_wr_ok(left_wr_ok), .right_wr_ok(right_wr_ok));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic apply(input string tag, input bit md, input bit le, input int la,
                       input bit re, input int ra, input bit lw, input bit rw,
                       input bit lbi, input bit rbi);
    bit clash, ls, rs, lb, rb;
    int own;
    @(negedge clk);
    master_mode = md; left_en = le; left_addr = la[AW-1:0]; right_en = re;
    right_addr = ra[AW-1:0]; left_wr = lw; right_wr = rw;
    left_busy_in = lbi; right_busy_in = rbi;
    #1;
    clash = le && re && (la == ra);
    ls = m_le && (m_la == la);
    rs = m_re && (m_ra == ra);
    if (!clash)        own = 0;
    else if (m_own != 0) own = m_own;
    else if (rs && !ls) own = 2;
    else               own = 1;
    lb = md ? (own == 2) : lbi;
    rb = md ? (own == 1) : rbi;
    chk(tag, "left_busy_out",  left_busy_out,  md && own == 2);
    chk(tag, "right_busy_out", right_busy_out, md && own == 1);
    chk(tag, "left_wr_ok",  left_wr_ok,  lw && !lb);
    chk(tag, "right_wr_ok", right_wr_ok, rw && !rb);
    m_le = le; m_re = re; m_la = la; m_ra = ra; m_own = own;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset with a standing clash
    left_en = 1; right_en = 1; left_addr = 1; right_addr = 1; left_wr = 1; right_wr = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9", "left_busy_out in reset",  left_busy_out,  1'b0);
    chk("R9", "right_busy_out in reset", right_busy_out, 1'b0);
    @(negedge clk); rst_n = 1; #1;
    chk("R9", "right_busy_out after release", right_busy_out, 1'b1);
    chk("R9", "left_busy_out after release",  left_busy_out,  1'b0);
    m_le = 1; m_re = 1; m_la = 1; m_ra = 1; m_own = 1;

    apply("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1: only one port enabled on shared address
    apply("R1", 1, 1, 2, 0, 2, 1, 1, 0, 0);
    chk("R1", "no busy single port", left_busy_out | right_busy_out, 1'b0);

    // R3: right enabled first, left enables onto same address
    apply("R3", 1, 0, 2, 1, 2, 0, 0, 0, 0);
    apply("R3", 1, 1, 2, 1, 2, 1, 1, 0, 0);
    chk("R3", "late enable loses", left_busy_out, 1'b1);
    chk("R8", "loser write blocked", left_wr_ok, 1'b0);
    chk("R8", "winner write allowed", right_wr_ok, 1'b1);
    // R4: opponent disables
    apply("R4", 1, 1, 2, 0, 2, 1, 1, 0, 0);
    chk("R4", "release on opponent disable", left_busy_out, 1'b0);

    // R2: right moves its address onto stable left
    apply("R2", 1, 1, 0, 1, 1, 0, 0, 0, 0);
    apply("R2", 1, 1, 0, 1, 0, 0, 1, 0, 0);
    chk("R2", "mover loses", right_busy_out, 1'b1);
    // R6: both settle, winner held
    apply("R6", 1, 1, 0, 1, 0, 0, 1, 0, 0);
    chk("R6", "winner held", right_busy_out, 1'b1);
    // R6: move together to another shared address
    apply("R6", 1, 1, 3, 1, 3, 0, 1, 0, 0);
    chk("R6", "held across joint move", right_busy_out, 1'b1);
    // R4: address mismatch releases
    apply("R4", 1, 1, 2, 1, 3, 0, 1, 0, 0);
    chk("R4", "release on mismatch", right_busy_out, 1'b0);

    // R5: simultaneous arrival
    apply("R5", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R5", 1, 1, 1, 1, 1, 1, 1, 0, 0);
    chk("R5", "tie right busy", right_busy_out, 1'b1);
    chk("R5", "tie left free", left_busy_out, 1'b0);

    // R7: slave mode
    apply("R7", 0, 1, 1, 1, 1, 1, 1, 1, 0);
    chk("R7", "slave left busy out", left_busy_out, 1'b0);
    chk("R7", "slave right busy out", right_busy_out, 1'b0);
    chk("R7", "slave left write blocked", left_wr_ok, 1'b0);
    chk("R7", "slave right write allowed", right_wr_ok, 1'b1);

    // sweep over every ordered pair of port states, both modes
    for (int md = 0; md < 2; md++) begin
      for (int a = 0; a < 64; a++) begin
        for (int b = 0; b < 64; b++) begin
          int w = (a ^ (b * 5)) & 15;
          apply("R2", md[0], a[5], (a >> 3) & 3, a[2], a & 3, w[0], w[1], w[2], w[3]);
          apply("R6", md[0], b[5], (b >> 3) & 3, b[2], b & 3, w[3], w[2], w[1], w[0]);
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule